// File: doc/BRIEF.md
# Programmable Display Timing Engine

This block generates the raster timing for a display link from a single pixel clock. Software programs the line period, the sync pulse widths and the window limits over a simple word-addressed register port, then sets the run bit. A horizontal counter walks each line. A second counter walks the whole frame as one running pixel index, so every vertical quantity is an absolute pixel-clock offset from frame start: lines times line period, plus skew where software wants it. HSYNC, VSYNC and data enable come out registered, each with its own polarity inversion.

The display window is the area where picture content is allowed. A narrower active window, enabled separately on each axis, marks where upstream pixels are really shown. Display pixels outside the active window carry a border colour. Underflowed active pixels carry an underflow colour. A one-clock fetch-start pulse at a programmable frame offset tells the upstream fetch logic when to begin. Frame and line counters can be read back while the engine runs.

Top module: `dtg_top`

## Requirements
- R1: Word 2 holds the line period P in bits 31:16 and the HSYNC width in bits 15:0. The horizontal position x = k mod P. The raw HSYNC is high while x < width. Frame pixel index k (k = 0 right after start) shows at the outputs after the (k+2)-th rising edge counted from the edge that writes 1 to bit 0 of word 0 (run).
- R2: Word 3 holds the frame period F in pixel clocks, and the frame index is k mod F. Word 4 holds the VSYNC width V and word 13 the skew S, both in pixel clocks. The raw VSYNC is high while S <= index < S+V.
- R3: Word 9 packs the display horizontal end in bits 31:16 and the start in bits 15:0. Words 5 and 6 hold the display vertical start and end as frame indexes. Raw data enable is high only inside both inclusive ranges. When the active window is off, a data-enable pixel equals the pixel input sampled one clock earlier.
- R4: Word 1 bit 29 enables the active horizontal window, which uses the packed range in word 10. Word 1 bit 30 enables the active vertical window, which uses words 7 and 8. Each enabled window further narrows data enable. A pixel inside the display window but outside the active window is driven with the border colour in word 11, and data enable is low.
- R5: Outside the display window the pixel output is zero and the raw data enable is low.
- R6: If the underflow input is high in the clock before a data-enable pixel, that pixel equals the underflow colour in word 12. On non-data-enable pixels the underflow input has no effect.
- R7: In word 14, bit 0 inverts HSYNC, bit 1 inverts VSYNC and bit 2 inverts data enable.
- R8: With word 1 bit 31 set, fetch_o pulses for one clock on the pixel whose frame index equals word 18. With the bit clear, fetch_o stays low.
- R9: Word 16 reads the frame counter. When word 15 bit 0 is set, the counter increments on each wrap of the frame index; when the bit is clear, it holds.
- R10: Word 17 reads the line counter. It clears at each frame wrap and, when word 15 bit 1 is set, increments at each line wrap, so it reads the line of the current frame index.
- R11: While run is 0, the counters read zero. From the first clock on, HSYNC, VSYNC and data enable sit at the word 14 polarity bits, the pixel output is zero and fetch_o is low.
- R12: Every writable word reads back its fields in the bit positions above. Writes to the read-only words 16 and 17 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| pix_in | input | 24 | Upstream pixel for the next output clock |
| uflow_in | input | 1 | Upstream underflow for the next output clock |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable after polarity |
| pixel_o | output | 24 | Output pixel colour |
| fetch_o | output | 1 | One-clock fetch-start pulse |

## Verification
Two behaviours can fall on the same clock here. The first is an underflow on a pixel that is border or blank rather than active. The second is a frame wrap that is also a line wrap, where the line counter must clear and not step. The underflow input is driven on a fixed stride that is coprime with the line period, so over three frames it lands on border, blanking and active pixels alike. Each output pixel is compared against a colour chosen by arithmetic in the bench. The counters are read on every clock, including the clocks right after each frame boundary, and are compared with the values that follow from the elapsed pixel count.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int unsigned BUS_W   = 32;
    localparam int unsigned ADDR_W  = 5;
    localparam int unsigned LINE_W  = 16;
    localparam int unsigned POS_W   = 32;
    localparam int unsigned COLOR_W = 24;

    localparam int unsigned CFG_ACT_H_BIT = 29;
    localparam int unsigned CFG_ACT_V_BIT = 30;
    localparam int unsigned CFG_FETCH_BIT = 31;

    localparam logic [ADDR_W-1:0] A_RUN    = 5'd0;
    localparam logic [ADDR_W-1:0] A_CFG    = 5'd1;
    localparam logic [ADDR_W-1:0] A_HCTL   = 5'd2;
    localparam logic [ADDR_W-1:0] A_FRAME  = 5'd3;
    localparam logic [ADDR_W-1:0] A_VSW    = 5'd4;
    localparam logic [ADDR_W-1:0] A_DVS    = 5'd5;
    localparam logic [ADDR_W-1:0] A_DVE    = 5'd6;
    localparam logic [ADDR_W-1:0] A_AVS    = 5'd7;
    localparam logic [ADDR_W-1:0] A_AVE    = 5'd8;
    localparam logic [ADDR_W-1:0] A_DHCTL  = 5'd9;
    localparam logic [ADDR_W-1:0] A_AHCTL  = 5'd10;
    localparam logic [ADDR_W-1:0] A_BORDER = 5'd11;
    localparam logic [ADDR_W-1:0] A_UFLOW  = 5'd12;
    localparam logic [ADDR_W-1:0] A_SKEW   = 5'd13;
    localparam logic [ADDR_W-1:0] A_POL    = 5'd14;
    localparam logic [ADDR_W-1:0] A_CNTEN  = 5'd15;
    localparam logic [ADDR_W-1:0] A_FCNT   = 5'd16;
    localparam logic [ADDR_W-1:0] A_LCNT   = 5'd17;
    localparam logic [ADDR_W-1:0] A_FETCH  = 5'd18;

    typedef struct packed {
        logic [LINE_W-1:0] line_period;
        logic [POS_W-1:0]  frame_period;
        logic [1:0]        cnt_en;
    } scan_cfg_t;

    typedef struct packed {
        logic [LINE_W-1:0]  hs_width;
        logic [POS_W-1:0]   vs_width;
        logic [POS_W-1:0]   skew;
        logic [POS_W-1:0]   dv_start;
        logic [POS_W-1:0]   dv_end;
        logic [POS_W-1:0]   av_start;
        logic [POS_W-1:0]   av_end;
        logic [POS_W-1:0]   fetch_pos;
        logic [LINE_W-1:0]  dh_start;
        logic [LINE_W-1:0]  dh_end;
        logic [LINE_W-1:0]  ah_start;
        logic [LINE_W-1:0]  ah_end;
        logic               act_h_en;
        logic               act_v_en;
        logic               fetch_en;
        logic [2:0]         pol;
        logic [COLOR_W-1:0] border;
        logic [COLOR_W-1:0] uflow;
    } win_cfg_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [POS_W-1:0]  frame_cnt,
    input  logic [LINE_W-1:0] line_cnt,
    output logic [BUS_W-1:0]  rdata,
    output logic              run,
    output scan_cfg_t         scfg,
    output win_cfg_t          wcfg
);
    localparam int unsigned HI_LSB = LINE_W;
    localparam int unsigned HI_MSB = 2 * LINE_W - 1;

    typedef struct packed {
        logic      run;
        scan_cfg_t s;
        win_cfg_t  w;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr)
                A_RUN:    r_d.run = wdata[0];
                A_CFG: begin
                    r_d.w.act_h_en = wdata[CFG_ACT_H_BIT];
                    r_d.w.act_v_en = wdata[CFG_ACT_V_BIT];
                    r_d.w.fetch_en = wdata[CFG_FETCH_BIT];
                end
                A_HCTL: begin
                    r_d.s.line_period = wdata[HI_MSB:HI_LSB];
                    r_d.w.hs_width    = wdata[LINE_W-1:0];
                end
                A_FRAME:  r_d.s.frame_period = wdata[POS_W-1:0];
                A_VSW:    r_d.w.vs_width     = wdata[POS_W-1:0];
                A_DVS:    r_d.w.dv_start     = wdata[POS_W-1:0];
                A_DVE:    r_d.w.dv_end       = wdata[POS_W-1:0];
                A_AVS:    r_d.w.av_start     = wdata[POS_W-1:0];
                A_AVE:    r_d.w.av_end       = wdata[POS_W-1:0];
                A_DHCTL: begin
                    r_d.w.dh_end   = wdata[HI_MSB:HI_LSB];
                    r_d.w.dh_start = wdata[LINE_W-1:0];
                end
                A_AHCTL: begin
                    r_d.w.ah_end   = wdata[HI_MSB:HI_LSB];
                    r_d.w.ah_start = wdata[LINE_W-1:0];
                end
                A_BORDER: r_d.w.border    = wdata[COLOR_W-1:0];
                A_UFLOW:  r_d.w.uflow     = wdata[COLOR_W-1:0];
                A_SKEW:   r_d.w.skew      = wdata[POS_W-1:0];
                A_POL:    r_d.w.pol       = wdata[2:0];
                A_CNTEN:  r_d.s.cnt_en    = wdata[1:0];
                A_FETCH:  r_d.w.fetch_pos = wdata[POS_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_RUN:    rdata[0] = r_q.run;
            A_CFG: begin
                rdata[CFG_ACT_H_BIT] = r_q.w.act_h_en;
                rdata[CFG_ACT_V_BIT] = r_q.w.act_v_en;
                rdata[CFG_FETCH_BIT] = r_q.w.fetch_en;
            end
            A_HCTL:   rdata = {r_q.s.line_period, r_q.w.hs_width};
            A_FRAME:  rdata = r_q.s.frame_period;
            A_VSW:    rdata = r_q.w.vs_width;
            A_DVS:    rdata = r_q.w.dv_start;
            A_DVE:    rdata = r_q.w.dv_end;
            A_AVS:    rdata = r_q.w.av_start;
            A_AVE:    rdata = r_q.w.av_end;
            A_DHCTL:  rdata = {r_q.w.dh_end, r_q.w.dh_start};
            A_AHCTL:  rdata = {r_q.w.ah_end, r_q.w.ah_start};
            A_BORDER: rdata[COLOR_W-1:0] = r_q.w.border;
            A_UFLOW:  rdata[COLOR_W-1:0] = r_q.w.uflow;
            A_SKEW:   rdata = r_q.w.skew;
            A_POL:    rdata[2:0] = r_q.w.pol;
            A_CNTEN:  rdata[1:0] = r_q.s.cnt_en;
            A_FCNT:   rdata = frame_cnt;
            A_LCNT:   rdata[LINE_W-1:0] = line_cnt;
            A_FETCH:  rdata = r_q.w.fetch_pos;
            default:  rdata = '0;
        endcase
    end

    assign run  = r_q.run;
    assign scfg = r_q.s;
    assign wcfg = r_q.w;

    // R12: a write to a read-only counter word leaves every stored field untouched
    p_ro_write_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == A_FCNT || addr == A_LCNT)) |=> (r_q == $past(r_q)));
endmodule

// File: rtl/dtg_scan.sv
module dtg_scan
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  scan_cfg_t         scfg,
    output logic [LINE_W-1:0] hx,
    output logic [POS_W-1:0]  pidx,
    output logic [LINE_W-1:0] line_cnt,
    output logic [POS_W-1:0]  frame_cnt
);
    typedef struct packed {
        logic [LINE_W-1:0] hx;
        logic [POS_W-1:0]  pidx;
        logic [LINE_W-1:0] line;
        logic [POS_W-1:0]  frame;
    } scan_t;

    scan_t st_d, st_q;
    logic [LINE_W:0] hx_inc;
    logic [POS_W:0]  pidx_inc;
    logic            h_wrap, f_wrap;

    always_comb begin
        hx_inc   = {1'b0, st_q.hx} + 1'b1;
        pidx_inc = {1'b0, st_q.pidx} + 1'b1;
        h_wrap   = hx_inc >= {1'b0, scfg.line_period};
        f_wrap   = pidx_inc >= {1'b0, scfg.frame_period};
        st_d     = st_q;
        if (!run) begin
            st_d = '0;
        end else begin
            st_d.hx   = h_wrap ? '0 : hx_inc[LINE_W-1:0];
            st_d.pidx = f_wrap ? '0 : pidx_inc[POS_W-1:0];
            if (f_wrap) begin
                st_d.line = '0;
                if (scfg.cnt_en[0]) st_d.frame = st_q.frame + 1'b1;
            end else if (h_wrap && scfg.cnt_en[1]) begin
                st_d.line = st_q.line + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hx        = st_q.hx;
    assign pidx      = st_q.pidx;
    assign line_cnt  = st_q.line;
    assign frame_cnt = st_q.frame;

    // R1: the horizontal position returns to zero after the last pixel of a line
    p_line_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && scfg.line_period != '0 && {1'b0, st_q.hx} == {1'b0, scfg.line_period} - 1'b1)
        |=> (st_q.hx == '0));

    // R9: the frame counter only moves on the clock the frame index returns to zero
    p_frame_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pidx != '0) |-> $stable(st_q.frame));

    // R11: a stopped engine leaves all counters at zero one clock later
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q == '0));
endmodule

// File: rtl/dtg_decode.sv
module dtg_decode
    import dtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  win_cfg_t           wcfg,
    input  logic [LINE_W-1:0]  hx,
    input  logic [POS_W-1:0]   pidx,
    input  logic [COLOR_W-1:0] pix_in,
    input  logic               uflow_in,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic               fetch,
    output logic [COLOR_W-1:0] pixel
);
    localparam int unsigned N_WIN = 4;

    typedef struct packed {
        logic               hs;
        logic               vs;
        logic               de;
        logic               fetch;
        logic [COLOR_W-1:0] pixel;
    } vid_t;

    vid_t o_d, o_q;

    logic [POS_W-1:0] win_pos [N_WIN];
    logic [POS_W-1:0] win_lo  [N_WIN];
    logic [POS_W-1:0] win_hi  [N_WIN];
    logic [N_WIN-1:0] win_in;
    logic [POS_W-1:0] hx_ext;
    logic [POS_W:0]   vs_end;
    logic             hs_raw, vs_raw, in_disp, in_act, de_raw;

    assign hx_ext = {{(POS_W-LINE_W){1'b0}}, hx};

    always_comb begin
        win_pos[0] = hx_ext;
        win_lo[0]  = {{(POS_W-LINE_W){1'b0}}, wcfg.dh_start};
        win_hi[0]  = {{(POS_W-LINE_W){1'b0}}, wcfg.dh_end};
        win_pos[1] = pidx;
        win_lo[1]  = wcfg.dv_start;
        win_hi[1]  = wcfg.dv_end;
        win_pos[2] = hx_ext;
        win_lo[2]  = {{(POS_W-LINE_W){1'b0}}, wcfg.ah_start};
        win_hi[2]  = {{(POS_W-LINE_W){1'b0}}, wcfg.ah_end};
        win_pos[3] = pidx;
        win_lo[3]  = wcfg.av_start;
        win_hi[3]  = wcfg.av_end;
    end

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        assign win_in[g] = (win_pos[g] >= win_lo[g]) && (win_pos[g] <= win_hi[g]);
    end

    always_comb begin
        vs_end  = {1'b0, wcfg.skew} + {1'b0, wcfg.vs_width};
        hs_raw  = hx < wcfg.hs_width;
        vs_raw  = (pidx >= wcfg.skew) && ({1'b0, pidx} < vs_end);
        in_disp = win_in[0] & win_in[1];
        in_act  = (win_in[2] | ~wcfg.act_h_en) & (win_in[3] | ~wcfg.act_v_en);
        de_raw  = in_disp & in_act;

        o_d = '0;
        if (!run) begin
            o_d.hs = wcfg.pol[0];
            o_d.vs = wcfg.pol[1];
            o_d.de = wcfg.pol[2];
        end else begin
            o_d.hs    = hs_raw ^ wcfg.pol[0];
            o_d.vs    = vs_raw ^ wcfg.pol[1];
            o_d.de    = de_raw ^ wcfg.pol[2];
            o_d.fetch = wcfg.fetch_en && (pidx == wcfg.fetch_pos);
            if (de_raw)       o_d.pixel = uflow_in ? wcfg.uflow : pix_in;
            else if (in_disp) o_d.pixel = wcfg.border;
            else              o_d.pixel = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign hsync = o_q.hs;
    assign vsync = o_q.vs;
    assign de    = o_q.de;
    assign fetch = o_q.fetch;
    assign pixel = o_q.pixel;

    // R6: an enabled pixel that followed an underflow carries the underflow colour
    p_uflow_colour_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((o_q.de != wcfg.pol[2]) && $stable(wcfg.pol) && $past(uflow_in) && $past(run))
        |-> (o_q.pixel == $past(wcfg.uflow)));
endmodule

// File: rtl/dtg_top.sv
module dtg_top
    import dtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [COLOR_W-1:0] pix_in,
    input  logic               uflow_in,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               de_o,
    output logic [COLOR_W-1:0] pixel_o,
    output logic               fetch_o
);
    logic              run;
    scan_cfg_t         scfg;
    win_cfg_t          wcfg;
    logic [LINE_W-1:0] hx, line_cnt;
    logic [POS_W-1:0]  pidx, frame_cnt;

    dtg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .frame_cnt (frame_cnt),
        .line_cnt  (line_cnt),
        .rdata     (bus_rdata),
        .run       (run),
        .scfg      (scfg),
        .wcfg      (wcfg)
    );

    dtg_scan u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .scfg      (scfg),
        .hx        (hx),
        .pidx      (pidx),
        .line_cnt  (line_cnt),
        .frame_cnt (frame_cnt)
    );

    dtg_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .wcfg     (wcfg),
        .hx       (hx),
        .pidx     (pidx),
        .pix_in   (pix_in),
        .uflow_in (uflow_in),
        .hsync    (hsync_o),
        .vsync    (vsync_o),
        .de       (de_o),
        .fetch    (fetch_o),
        .pixel    (pixel_o)
    );

    // R11: two idle clocks leave every output at its inactive level
    p_idle_outputs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run) && $stable(wcfg.pol))
        |-> (hsync_o == wcfg.pol[0] && vsync_o == wcfg.pol[1] &&
             de_o == wcfg.pol[2] && pixel_o == '0 && !fetch_o));

    // R8: the fetch pulse lasts one clock when a frame spans more than one pixel
    p_fetch_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_o && scfg.frame_period > 1 && $stable(wcfg.fetch_pos))
        |=> !fetch_o);
endmodule

// File: tb/sim_dtg_top.sv
module sim_dtg_top;
    import dtg_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic               bus_we = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [BUS_W-1:0]   bus_wdata = '0;
    logic [BUS_W-1:0]   bus_rdata;
    logic [COLOR_W-1:0] pix_in = '0;
    logic               uflow_in = 1'b0;
    logic               hsync_o, vsync_o, de_o, fetch_o;
    logic [COLOR_W-1:0] pixel_o;

    dtg_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_in(pix_in),
        .uflow_in(uflow_in), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .pixel_o(pixel_o), .fetch_o(fetch_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int lp, hw, fp, vw, sk, dvs, dve, avs, ave, dhs, dhe, ahs, ahe, fpos;
    bit ahen, aven, fen;
    bit [2:0] pol;
    bit [1:0] cen;
    logic [COLOR_W-1:0] bcol, ucol;

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic program_all();
        wr(A_HCTL,   (32'(lp) << 16) | 32'(hw));
        wr(A_FRAME,  32'(fp));
        wr(A_VSW,    32'(vw));
        wr(A_SKEW,   32'(sk));
        wr(A_DVS,    32'(dvs));
        wr(A_DVE,    32'(dve));
        wr(A_AVS,    32'(avs));
        wr(A_AVE,    32'(ave));
        wr(A_DHCTL,  (32'(dhe) << 16) | 32'(dhs));
        wr(A_AHCTL,  (32'(ahe) << 16) | 32'(ahs));
        wr(A_BORDER, 32'(bcol));
        wr(A_UFLOW,  32'(ucol));
        wr(A_POL,    32'(pol));
        wr(A_CNTEN,  32'(cen));
        wr(A_FETCH,  32'(fpos));
        wr(A_CFG,    {fen, aven, ahen, 29'd0});
    endtask

    // Starts the engine and compares every output and both counters for ncyc pixels.
    task automatic sweep(input int ncyc);
        logic [31:0] v;
        wr(A_RUN, 32'd1);
        for (int k = 0; k < ncyc; k++) begin
            automatic int x = k % lp;
            automatic int p = k % fp;
            automatic bit uf = ((k % 13) == 5);
            automatic logic [COLOR_W-1:0] pin = COLOR_W'(k * 37 + 5);
            automatic bit hs_r, vs_r, disp, act, der;
            automatic logic [COLOR_W-1:0] ep;
            automatic string rp, rs;
            pix_in = pin;
            uflow_in = uf;
            @(negedge clk);
            hs_r = (x < hw);
            vs_r = (p >= sk) && (p < sk + vw);
            disp = (x >= dhs) && (x <= dhe) && (p >= dvs) && (p <= dve);
            act  = (!ahen || (x >= ahs && x <= ahe)) && (!aven || (p >= avs && p <= ave));
            der  = disp && act;
            if (der && uf)  begin ep = ucol; rp = "R6"; end
            else if (der)   begin ep = pin;  rp = "R3"; end
            else if (disp)  begin ep = bcol; rp = "R4"; end
            else            begin ep = '0;   rp = "R5"; end
            rs = (pol != 3'b000) ? "R7" : "R1";
            chk(rs, "hsync", longint'(hsync_o), longint'(hs_r ^ pol[0]));
            chk((pol != 3'b000) ? "R7" : "R2", "vsync", longint'(vsync_o), longint'(vs_r ^ pol[1]));
            chk((ahen || aven) ? "R4" : "R3", "de", longint'(de_o), longint'(der ^ pol[2]));
            chk(rp, "pixel", longint'(pixel_o), longint'(ep));
            chk("R8", "fetch", longint'(fetch_o), longint'(fen && (p == fpos)));
            rd(A_FCNT, v);
            chk("R9", "frame_cnt", longint'(v), cen[0] ? longint'((k + 1) / fp) : 0);
            rd(A_LCNT, v);
            chk("R10", "line_cnt", longint'(v), cen[1] ? longint'(((k + 1) % fp) / lp) : 0);
        end
        uflow_in = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        logic [31:0] v;
        chk("R11", {tag, " hsync"}, longint'(hsync_o), longint'(pol[0]));
        chk("R11", {tag, " vsync"}, longint'(vsync_o), longint'(pol[1]));
        chk("R11", {tag, " de"},    longint'(de_o),    longint'(pol[2]));
        chk("R11", {tag, " pixel"}, longint'(pixel_o), 0);
        chk("R11", {tag, " fetch"}, longint'(fetch_o), 0);
        rd(A_FCNT, v);
        chk("R11", {tag, " frame_cnt"}, longint'(v), 0);
        rd(A_LCNT, v);
        chk("R11", {tag, " line_cnt"}, longint'(v), 0);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        pol = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("reset");
        rd(A_CFG, v);
        chk("R12", "cfg after reset", longint'(v), 0);

        // Frame A: 10-clock lines, 6 lines, narrowed active window, fetch pulse.
        lp = 10; hw = 2; fp = 60; vw = 10; sk = 0;
        dhs = 3; dhe = 7; dvs = 20; dve = 49;
        ahs = 4; ahe = 6; avs = 30; ave = 39;
        ahen = 1'b1; aven = 1'b1; fen = 1'b1; fpos = 55;
        pol = 3'b000; cen = 2'b11;
        bcol = 24'hABCDEF; ucol = 24'h123456;
        program_all();
        @(negedge clk);
        rd(A_HCTL, v);
        chk("R12", "hctl readback", longint'(v), longint'((32'(lp) << 16) | 32'(hw)));
        rd(A_CFG, v);
        chk("R12", "cfg readback", longint'(v), longint'({3'b111, 29'd0}));
        rd(A_DHCTL, v);
        chk("R12", "dhctl readback", longint'(v), longint'((32'(dhe) << 16) | 32'(dhs)));
        wr(A_FCNT, 32'h55);
        rd(A_FCNT, v);
        chk("R12", "ro frame_cnt write", longint'(v), 0);
        wr(A_LCNT, 32'h7);
        rd(A_LCNT, v);
        chk("R12", "ro line_cnt write", longint'(v), 0);
        check_idle("before start");
        sweep(3 * fp + 7);

        // Stop mid-frame.
        wr(A_RUN, 32'd0);
        @(negedge clk);
        check_idle("after stop");
        @(negedge clk);
        check_idle("stopped");

        // Frame B: inverted polarities, skew, no active window, no fetch, counters off.
        pol = 3'b111; sk = 3; dvs = 23; dve = 52;
        ahen = 1'b0; aven = 1'b0; fen = 1'b0; cen = 2'b00;
        program_all();
        @(negedge clk);
        check_idle("inverted idle");
        sweep(2 * fp + 5);

        // Frame C: frame counter only, line counter held at zero.
        wr(A_RUN, 32'd0);
        pol = 3'b010; cen = 2'b01; fen = 1'b1; fpos = 2; sk = 0; dvs = 20; dve = 49;
        program_all();
        @(negedge clk);
        check_idle("mixed idle");
        sweep(2 * fp + 3);

        done = 1'b1;
        report();
        $finish;
    end
endmodule